// File: doc/BRIEF.md
# TLB Entry Store with Software Maintenance Port

This block keeps the translation entries of a memory management unit: a small
instruction-side table of four entries and a unified table of sixty-four
entries. Each entry holds a virtual page number, an 8-bit address-space
identifier, a physical page number and nine flag bits. Unified entries also
carry a 4-bit assistance field. Software reads and writes the entries through
a simple register bus, using separate address-view and data-view windows for
each table. The same bus reaches a control register and three staging
registers that hold a page-table entry.

The control register holds three 6-bit fields: a replacement counter, a
replacement boundary and a recency field. A control write with the kill bit
set clears the valid flag of every entry in both tables. A one-cycle load
strobe copies the staged page-table entry into the unified entry that the
replacement counter points at. The address match used for translation is not
part of this block. Reads are combinational. Writes and loads take effect at
the next rising clock edge.

Bus address bits 27:24 select a region: 0 control, 1 entry-high staging,
2 entry-low staging, 3 assistance staging, 4 instruction address view,
5 instruction data view, 6 unified address view, 7 unified data view. Regions
8 to 15 are unmapped.

Top module: `tlb_maint`

## Requirements
- R1: After reset, every readable location returns zero. This includes all valid flags and the three control-register fields.
- R2: `busRdData` is zero whenever `busRdEn` is low, and also when the address selects an unmapped region. A write to an unmapped region changes nothing.
- R3: A control write loads the counter from data bits 15:10, the boundary from bits 23:18 and the recency field from bits 31:26. It keeps the remaining bits except bit 2. A control read returns the kept bits OR the counter shifted left by 10, the boundary shifted left by 18 and the recency field shifted left by 26.
- R4: A control write with data bit 2 set clears the valid flag (flag bit 8) of all 4 instruction entries and all 64 unified entries. Bit 2 always reads back as zero.
- R5: Address bits 8:7 select the instruction entry. Address bits 13:8 select the unified entry.
- R6: An instruction address-view write sets the VPN from data bits 31:10, the ASID from bits 7:0 and valid from bit 8, and leaves the other flags unchanged. Its read returns VPN, bit 8 as valid, and the ASID.
- R7: An instruction data-view write keeps the PPN under mask 0x1FFFFC00 and the flags under mask 0x1DA. Its read returns PPN OR flags.
- R8: A unified address-view write with address bit 7 clear sets the VPN and ASID, sets valid from data bit 8 and sets the dirty flag (flag bit 2) from data bit 9. Its read returns VPN, dirty at bit 9, valid at bit 8, and the ASID.
- R9: A unified address-view write with address bit 7 set leaves every entry unchanged.
- R10: A unified data-view write with address bit 23 clear sets the PPN (mask 0x1FFFFC00) and all nine flags (mask 0x1FF). Its read returns PPN OR flags.
- R11: A unified data-view access with address bit 23 set reaches the assistance field. A write stores data bits 3:0, and a read returns that field zero-extended. The primary data word is untouched.
- R12: A load strobe writes into the unified entry indexed by the counter. The VPN and ASID come from entry-high staging, the PPN and flags (mask 0x1FF) from entry-low staging, and the assistance field from bits 3:0 of assistance staging. The control register and the instruction table stay unchanged.
- R13: The three staging registers read back all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 32 | Register bus address |
| busWrData | input | 32 | Write data |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe; read data is combinational |
| busRdData | output | 32 | Read data, zero when not reading |
| ldTlb | input | 1 | Load staged entry into the unified table |

## Verification
The checks assume that a bus write and a load strobe are never raised in the same cycle, and one assertion watches for that case. They also assume that address bits outside the region, index, bit 7 and bit 23 fields carry no meaning. The stimulus drives at most one operation per cycle and changes inputs only on the falling edge. It sets only the decoded address bits, and it builds every random address from a region code and a masked random field.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;
  localparam int FIELD_W  = 6;
  localparam int VPN_W    = 22;
  localparam int ASID_W   = 8;
  localparam int PPN_W    = 19;
  localparam int FLAG_W   = 9;
  localparam int AUX_W    = 4;
  localparam int VALID_BIT = 8;
  localparam int DIRTY_BIT = 2;
  localparam int KILL_BIT  = 2;
  localparam int URC_LO = 10;
  localparam int URB_LO = 18;
  localparam int LRU_LO = 26;
  localparam logic [31:0]       CTRL_KEEP   = ~32'hFCFC_FC04;
  localparam logic [FLAG_W-1:0] I_FLAG_MASK = 9'h1DA;

  typedef enum logic [2:0] {
    RG_CTRL, RG_PTEH, RG_PTEL, RG_PTEA, RG_IADDR, RG_IDATA, RG_UADDR, RG_UDATA
  } region_e;

  typedef struct packed {
    logic ctrlWr;
    logic ptehWr;
    logic ptelWr;
    logic pteaWr;
    logic iAddrWr;
    logic iDataWr;
    logic uAddrWr;
    logic uDataWr;
    logic uAuxWr;
    logic load;
  } strobe_t;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [FLAG_W-1:0] flags;
  } entry_t;
endpackage

// File: rtl/tlb_maint_ctrl.sv
module tlb_maint_ctrl
  import tlb_maint_pkg::*;
#(
  parameter int REGION_LO = 24,
  parameter int AUX_BIT   = 23,
  parameter int ASSOC_BIT = 7,
  parameter int I_IDX_LO  = 7,
  parameter int U_IDX_LO  = 8,
  parameter int I_IDX_W   = 2,
  parameter int U_IDX_W   = 6
) (
  input  logic [31:0]        busAddr,
  input  logic               busWrEn,
  input  logic               busRdEn,
  input  logic               ldTlb,
  output strobe_t            strobe,
  output region_e            rdSel,
  output logic               rdHit,
  output logic               auxSel,
  output logic [I_IDX_W-1:0] iIdx,
  output logic [U_IDX_W-1:0] uIdx
);
  logic [3:0] region;
  logic       mapped;

  assign region = busAddr[REGION_LO +: 4];
  assign mapped = ~region[3];
  assign rdSel  = region_e'(region[2:0]);
  assign rdHit  = busRdEn & mapped;
  assign auxSel = busAddr[AUX_BIT];
  assign iIdx   = busAddr[I_IDX_LO +: I_IDX_W];
  assign uIdx   = busAddr[U_IDX_LO +: U_IDX_W];

  always_comb begin
    strobe      = '0;
    strobe.load = ldTlb;
    if (busWrEn && mapped) begin
      case (rdSel)
        RG_CTRL:  strobe.ctrlWr  = 1'b1;
        RG_PTEH:  strobe.ptehWr  = 1'b1;
        RG_PTEL:  strobe.ptelWr  = 1'b1;
        RG_PTEA:  strobe.pteaWr  = 1'b1;
        RG_IADDR: strobe.iAddrWr = 1'b1;
        RG_IDATA: strobe.iDataWr = 1'b1;
        RG_UADDR: strobe.uAddrWr = ~busAddr[ASSOC_BIT];
        RG_UDATA: begin
          strobe.uDataWr = ~busAddr[AUX_BIT];
          strobe.uAuxWr  = busAddr[AUX_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tlb_maint_dp.sv
module tlb_maint_dp
  import tlb_maint_pkg::*;
#(
  parameter int I_ENTRIES = 4,
  parameter int U_ENTRIES = 64,
  localparam int I_IDX_W = $clog2(I_ENTRIES),
  localparam int U_IDX_W = $clog2(U_ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  region_e            rdSel,
  input  logic               rdHit,
  input  logic               auxSel,
  input  logic [I_IDX_W-1:0] iIdx,
  input  logic [U_IDX_W-1:0] uIdx,
  input  logic [31:0]        busWrData,
  output logic [31:0]        busRdData
);
  logic [31:0]        ctrlKeep, pteh, ptel, ptea;
  logic [FIELD_W-1:0] urc, urb, lru;
  logic               killAll;
  logic [U_IDX_W-1:0] loadIdx;
  entry_t             iView [I_ENTRIES];
  entry_t             uView [U_ENTRIES];
  logic [AUX_W-1:0]   auxView [U_ENTRIES];
  entry_t             iSel, uSel;
  logic [31:0]        rdVal;

  assign killAll = strobe.ctrlWr & busWrData[KILL_BIT];
  assign loadIdx = urc[U_IDX_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlKeep <= '0; pteh <= '0; ptel <= '0; ptea <= '0;
      urc <= '0; urb <= '0; lru <= '0;
    end else begin
      if (strobe.ctrlWr) begin
        ctrlKeep <= busWrData & CTRL_KEEP;
        urc      <= busWrData[URC_LO +: FIELD_W];
        urb      <= busWrData[URB_LO +: FIELD_W];
        lru      <= busWrData[LRU_LO +: FIELD_W];
      end
      if (strobe.ptehWr) pteh <= busWrData;
      if (strobe.ptelWr) ptel <= busWrData;
      if (strobe.pteaWr) ptea <= busWrData;
    end
  end

  for (genvar k = 0; k < I_ENTRIES; k++) begin : gIRow
    entry_t ent;
    logic   hit;
    assign hit = (iIdx == I_IDX_W'(k));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ent <= '0;
      else if (killAll) ent.flags[VALID_BIT] <= 1'b0;
      else if (strobe.iAddrWr && hit) begin
        ent.vpn              <= busWrData[31:10];
        ent.asid             <= busWrData[7:0];
        ent.flags[VALID_BIT] <= busWrData[8];
      end else if (strobe.iDataWr && hit) begin
        ent.ppn   <= busWrData[28:10];
        ent.flags <= busWrData[8:0] & I_FLAG_MASK;
      end
    end
    assign iView[k] = ent;
  end

  for (genvar k = 0; k < U_ENTRIES; k++) begin : gURow
    entry_t           ent;
    logic [AUX_W-1:0] aux;
    logic             hit, ldHit;
    assign hit   = (uIdx == U_IDX_W'(k));
    assign ldHit = (loadIdx == U_IDX_W'(k));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ent <= '0;
        aux <= '0;
      end else if (killAll) ent.flags[VALID_BIT] <= 1'b0;
      else if (strobe.load && ldHit) begin
        ent.vpn   <= pteh[31:10];
        ent.asid  <= pteh[7:0];
        ent.ppn   <= ptel[28:10];
        ent.flags <= ptel[8:0];
        aux       <= ptea[AUX_W-1:0];
      end else if (strobe.uAddrWr && hit) begin
        ent.vpn              <= busWrData[31:10];
        ent.asid             <= busWrData[7:0];
        ent.flags[VALID_BIT] <= busWrData[8];
        ent.flags[DIRTY_BIT] <= busWrData[9];
      end else if (strobe.uDataWr && hit) begin
        ent.ppn   <= busWrData[28:10];
        ent.flags <= busWrData[8:0];
      end else if (strobe.uAuxWr && hit) aux <= busWrData[AUX_W-1:0];
    end
    assign uView[k]   = ent;
    assign auxView[k] = aux;
  end

  always_comb begin
    iSel  = iView[iIdx];
    uSel  = uView[uIdx];
    rdVal = '0;
    case (rdSel)
      RG_CTRL:  rdVal = ctrlKeep | {lru, 2'b00, urb, 2'b00, urc, 10'b0};
      RG_PTEH:  rdVal = pteh;
      RG_PTEL:  rdVal = ptel;
      RG_PTEA:  rdVal = ptea;
      RG_IADDR: rdVal = {iSel.vpn, 1'b0, iSel.flags[VALID_BIT], iSel.asid};
      RG_IDATA: rdVal = {3'b0, iSel.ppn, 1'b0, iSel.flags};
      RG_UADDR: rdVal = {uSel.vpn, uSel.flags[DIRTY_BIT], uSel.flags[VALID_BIT], uSel.asid};
      RG_UDATA: rdVal = auxSel ? {{(32-AUX_W){1'b0}}, auxView[uIdx]}
                               : {3'b0, uSel.ppn, 1'b0, uSel.flags};
      default:  rdVal = '0;
    endcase
    busRdData = rdHit ? rdVal : '0;
  end
endmodule

// File: rtl/tlb_maint.sv
module tlb_maint
  import tlb_maint_pkg::*;
#(
  parameter int I_ENTRIES = 4,
  parameter int U_ENTRIES = 64,
  parameter int I_IDX_LO  = 7,
  parameter int U_IDX_LO  = 8,
  parameter int REGION_LO = 24,
  parameter int AUX_BIT   = 23,
  parameter int ASSOC_BIT = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] busAddr,
  input  logic [31:0] busWrData,
  input  logic        busWrEn,
  input  logic        busRdEn,
  output logic [31:0] busRdData,
  input  logic        ldTlb
);
  localparam int I_IDX_W = $clog2(I_ENTRIES);
  localparam int U_IDX_W = $clog2(U_ENTRIES);

  strobe_t            strobe;
  region_e            rdSel;
  logic               rdHit, auxSel;
  logic [I_IDX_W-1:0] iIdx;
  logic [U_IDX_W-1:0] uIdx;

  tlb_maint_ctrl #(
    .REGION_LO(REGION_LO), .AUX_BIT(AUX_BIT), .ASSOC_BIT(ASSOC_BIT),
    .I_IDX_LO(I_IDX_LO), .U_IDX_LO(U_IDX_LO),
    .I_IDX_W(I_IDX_W), .U_IDX_W(U_IDX_W)
  ) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn), .ldTlb(ldTlb),
    .strobe(strobe), .rdSel(rdSel), .rdHit(rdHit), .auxSel(auxSel),
    .iIdx(iIdx), .uIdx(uIdx)
  );

  tlb_maint_dp #(
    .I_ENTRIES(I_ENTRIES), .U_ENTRIES(U_ENTRIES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdSel(rdSel), .rdHit(rdHit),
    .auxSel(auxSel), .iIdx(iIdx), .uIdx(uIdx), .busWrData(busWrData),
    .busRdData(busRdData)
  );
endmodule

// File: rtl/tlb_maint_chk.sv
module tlb_maint_chk
  import tlb_maint_pkg::*;
#(
  parameter int REGION_LO = 24,
  parameter int AUX_BIT   = 23,
  parameter int ASSOC_BIT = 7
) (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] busAddr,
  input logic [31:0] busWrData,
  input logic        busWrEn,
  input logic        busRdEn,
  input logic [31:0] busRdData,
  input logic        ldTlb,
  input strobe_t     strobe
);
  logic [3:0] region;
  assign region = busAddr[REGION_LO +: 4];

  // R2
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> busRdData == 32'h0);

  // R2
  one_op_per_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && ldTlb));

  // R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  // R3
  ctrl_fields_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && region == 4'd0) |=>
      (!(busRdEn && region == 4'd0) ||
       ((busRdData & 32'hFCFC_FC04) == ($past(busWrData) & 32'hFCFC_FC00))));

  // R4
  kill_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && region == 4'd0 && busWrData[2]) |=>
      (!(busRdEn && (region == 4'd4 || region == 4'd6)) || busRdData[8] == 1'b0));

  // R8
  dirty_move_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && region == 4'd6 && !busAddr[ASSOC_BIT]) |=>
      (!(busRdEn && busAddr == $past(busAddr)) ||
       busRdData[9:8] == $past(busWrData[9:8])));

  // R7
  idata_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && region == 4'd5) |-> (busRdData & ~32'h1FFF_FDDA) == 32'h0);

  // R11
  aux_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && region == 4'd7 && busAddr[AUX_BIT]) |-> busRdData[31:4] == 28'h0);
endmodule

bind tlb_maint tlb_maint_chk #(
  .REGION_LO(REGION_LO), .AUX_BIT(AUX_BIT), .ASSOC_BIT(ASSOC_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
  .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData),
  .ldTlb(ldTlb), .strobe(strobe)
);

// File: tb/tlb_maint_tb.sv
module tlb_maint_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0, busWrData = '0;
  logic        busWrEn = 1'b0, busRdEn = 1'b0, ldTlb = 1'b0;
  logic [31:0] busRdData;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] mKeep, mPteh, mPtel, mPtea;
  logic [5:0]  mUrc, mUrb, mLru;
  logic [31:0] iVa [4];
  logic [31:0] iLo [4];
  logic [31:0] uVa [64];
  logic [31:0] uLo [64];
  logic [31:0] uAs [64];

  tlb_maint u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busRdData(busRdData), .ldTlb(ldTlb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mRead(input logic [31:0] a);
    int r = int'(a[27:24]);
    int i = int'(a[8:7]);
    int u = int'(a[13:8]);
    case (r)
      0: return mKeep | (32'(mUrc) << 10) | (32'(mUrb) << 18) | (32'(mLru) << 26);
      1: return mPteh;
      2: return mPtel;
      3: return mPtea;
      4: return iVa[i] | (iLo[i] & 32'h100);
      5: return iLo[i];
      6: return uVa[u] | (uLo[u] & 32'h100) | ((uLo[u] & 32'h4) << 7);
      7: return a[23] ? uAs[u] : uLo[u];
      default: return 32'h0;
    endcase
  endfunction

  task automatic mUpdate(input logic wr, input logic ld, input logic [31:0] a, input logic [31:0] d);
    int r = int'(a[27:24]);
    int i = int'(a[8:7]);
    int u = int'(a[13:8]);
    if (ld) begin
      uVa[mUrc] = mPteh & 32'hFFFF_FCFF;
      uLo[mUrc] = mPtel & 32'h1FFF_FDFF;
      uAs[mUrc] = mPtea & 32'hF;
    end else if (wr) begin
      case (r)
        0: begin
          mKeep = d & ~32'hFCFC_FC04;
          mUrc = d[15:10]; mUrb = d[23:18]; mLru = d[31:26];
          if (d[2]) begin
            for (int k = 0; k < 4; k++) iLo[k] &= ~32'h100;
            for (int k = 0; k < 64; k++) uLo[k] &= ~32'h100;
          end
        end
        1: mPteh = d;
        2: mPtel = d;
        3: mPtea = d;
        4: begin iVa[i] = d & 32'hFFFF_FCFF; iLo[i] = (iLo[i] & ~32'h100) | (d & 32'h100); end
        5: iLo[i] = d & 32'h1FFF_FDDA;
        6: if (!a[7]) begin
             uVa[u] = d & 32'hFFFF_FCFF;
             uLo[u] = (uLo[u] & ~32'h104) | (d & 32'h100) | ((d >> 7) & 32'h4);
           end
        7: if (a[23]) uAs[u] = d & 32'hF; else uLo[u] = d & 32'h1FFF_FDFF;
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic ld, input logic rd,
                      input logic [31:0] a, input logic [31:0] d, input string tag);
    busWrEn = wr; ldTlb = ld; busRdEn = rd; busAddr = a; busWrData = d;
    #1;
    check(tag, busRdData, rd ? mRead(a) : 32'h0);
    @(posedge clk);
    mUpdate(wr, ld, a, d);
    @(negedge clk);
  endtask

  function automatic logic [31:0] rg(input int r);
    return 32'(r) << 24;
  endfunction
  function automatic logic [31:0] iA(input int r, input int k);
    return rg(r) | (32'(k) << 7);
  endfunction
  function automatic logic [31:0] uA(input int r, input int k);
    return rg(r) | (32'(k) << 8);
  endfunction

  function automatic string tagOf(input int r);
    case (r)
      0: return "R3"; 1, 2, 3: return "R13"; 4: return "R6"; 5: return "R7";
      6: return "R8"; 7: return "R10"; default: return "R2";
    endcase
  endfunction

  initial begin
    mKeep = '0; mPteh = '0; mPtel = '0; mPtea = '0; mUrc = '0; mUrb = '0; mLru = '0;
    for (int k = 0; k < 4; k++) begin iVa[k] = '0; iLo[k] = '0; end
    for (int k = 0; k < 64; k++) begin uVa[k] = '0; uLo[k] = '0; uAs[k] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    step(0, 0, 1, rg(0), 0, "R1 ctrl");
    step(0, 0, 1, rg(1), 0, "R1 staging");
    for (int k = 0; k < 4; k++) step(0, 0, 1, iA(4, k), 0, "R1 itlb addr");
    step(0, 0, 1, uA(6, 63), 0, "R1 utlb addr");
    step(0, 0, 1, uA(7, 5), 0, "R1 utlb data");
    step(0, 0, 1, uA(7, 5) | 32'h0080_0000, 0, "R1 utlb aux");

    // R3: control fields and kept bits
    step(1, 0, 0, rg(0), 32'h5A4B_3C21, "R3 write");
    step(0, 0, 1, rg(0), 0, "R3 readback");
    step(1, 0, 1, rg(0), 32'hFFFF_FFFB, "R3 all ones");
    step(0, 0, 1, rg(0), 0, "R3 all ones readback");
    // R2: idle read and unmapped region
    step(0, 0, 0, rg(0), 0, "R2 idle");
    step(1, 0, 1, rg(9), 32'hFFFF_FFFF, "R2 unmapped");
    step(0, 0, 1, rg(0), 0, "R2 unmapped write ignored");

    // R13: staging registers
    step(1, 0, 0, rg(1), 32'hDEAD_BEEF, "R13 w");
    step(1, 0, 1, rg(2), 32'hF123_4567, "R13 w");
    step(1, 0, 1, rg(3), 32'h0000_00A9, "R13 w");
    for (int r = 1; r < 4; r++) step(0, 0, 1, rg(r), 0, "R13 readback");

    // R5 R6 R7: instruction table
    for (int k = 0; k < 4; k++) begin
      step(1, 0, 0, iA(4, k), 32'h1234_5400 + 32'(k) * 32'h0101_0411 | 32'h100, "R6 w");
      step(1, 0, 0, iA(5, k), 32'hFFFF_FFFF - 32'(k) * 32'h0010_0400, "R7 w");
    end
    for (int k = 0; k < 4; k++) begin
      step(0, 0, 1, iA(4, k), 0, "R5 R6 itlb addr");
      step(0, 0, 1, iA(5, k), 0, "R7 itlb data");
    end
    step(1, 0, 0, iA(4, 2), 32'hCAFE_0055, "R6 clear valid");
    step(0, 0, 1, iA(5, 2), 0, "R6 flags kept");

    // R8 R10 R11: unified table
    step(1, 0, 0, uA(7, 17), 32'hFFFF_FFFF, "R10 w");
    step(0, 0, 1, uA(7, 17), 0, "R10 data");
    step(1, 0, 0, uA(6, 17), 32'h8765_4200, "R8 w");
    step(0, 0, 1, uA(6, 17), 0, "R8 dirty readback");
    step(0, 0, 1, uA(7, 17), 0, "R8 flags kept");
    step(1, 0, 0, uA(6, 63), 32'h1111_1344, "R8 w");
    step(0, 0, 1, uA(6, 63), 0, "R5 R8 top index");
    step(1, 0, 0, uA(7, 17) | 32'h0080_0000, 32'hFFFF_FFF6, "R11 w");
    step(0, 0, 1, uA(7, 17) | 32'h0080_0000, 0, "R11 aux");
    step(0, 0, 1, uA(7, 17), 0, "R11 primary untouched");
    // R9: associative write ignored
    step(1, 0, 0, uA(6, 17) | 32'h80, 32'h0000_0000, "R9 w");
    step(0, 0, 1, uA(6, 17), 0, "R9 entry unchanged");
    step(0, 0, 1, uA(6, 17 ^ 1), 0, "R9 neighbour unchanged");

    // R12: load command
    step(1, 0, 0, rg(0), 32'h0000_1400, "R12 set counter");
    step(1, 0, 0, rg(1), 32'hABCD_E4F7, "R12 pteh");
    step(1, 0, 0, rg(2), 32'hFEDC_BBFF, "R12 ptel");
    step(0, 1, 1, rg(0), 0, "R12 load");
    step(0, 0, 1, uA(6, 5), 0, "R12 entry addr");
    step(0, 0, 1, uA(7, 5), 0, "R12 entry data");
    step(0, 0, 1, uA(7, 5) | 32'h0080_0000, 0, "R12 entry aux");
    step(0, 0, 1, rg(0), 0, "R12 ctrl unchanged");
    step(0, 0, 1, iA(4, 0), 0, "R12 itlb unchanged");

    // R4: invalidate all
    step(1, 0, 0, rg(0), 32'h0000_0004, "R4 kill");
    for (int k = 0; k < 4; k++) step(0, 0, 1, iA(4, k), 0, "R4 itlb valid");
    step(0, 0, 1, uA(6, 5), 0, "R4 utlb valid");
    step(0, 0, 1, uA(7, 17), 0, "R4 utlb flags");
    step(0, 0, 1, rg(0), 0, "R4 bit2 reads zero");

    // mixed traffic compared on every clock
    for (int n = 0; n < 3000; n++) begin
      int op = int'($urandom_range(0, 9));
      int rw = int'($urandom_range(0, 8));
      int rr = int'($urandom_range(0, 8));
      logic [31:0] wa = rg(rw) | ($urandom & 32'h0080_3F80);
      logic [31:0] ra = rg(rr) | ($urandom & 32'h0080_3F80);
      logic [31:0] wd = $urandom;
      if (rw == 0 && $urandom_range(0, 3) != 0) wd[2] = 1'b0;
      if (op == 0) step(0, 1, 1, ra, 0, "R12 mixed load");
      else if (op < 6) begin
        step(1, 0, 0, wa, wd, tagOf(rw));
        step(0, 0, 1, wa, 0, tagOf(rw));
      end else step(0, 0, 1, ra, 0, tagOf(rr));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule